// File: doc/BRIEF.md
# Register Address Decoder with Vector Commands

This block holds the register pointer of a programmable timing generator. A host presents a value on a 6-bit bus and pulses an active-low load strobe. When the strobe falls, the block either takes the bus value as a new address or, in auto-addressing mode, treats the pulse as a data write to the current register and steps the pointer. The address is decoded into one-hot select lines: line 0 for the status register and lines 1 to `NUM_DATA_REGS` for the data registers. All other addresses select nothing.

Four addresses are commands rather than selects. Addresses 22 and 54 put the block into the Restart state, which tells the counters to reinitialise from their programmed values. Addresses 23 and 55 put it into the Clear state, which tells every register to go to zero. In either state the internal clock enable is held low, so the rest of the device is frozen. The command state ends when an ordinary address is loaded. The block then waits in a Resume state with the clock still gated, and normal running starts when that load strobe rises again.

State machine: `ST_RUN` (clock enabled), `ST_RESTART`, `ST_CLEAR` and `ST_RESUME` (all three gated). Transitions happen only on strobe edges. A falling edge that leaves a restart address goes to `ST_RESTART` from any state. A falling edge that leaves a clear address goes to `ST_CLEAR` from any state. A falling edge that leaves an ordinary address keeps `ST_RUN` as `ST_RUN` and moves any other state to `ST_RESUME`. A rising edge moves `ST_RESUME` to `ST_RUN`. All other edges keep the state.

Top module: `regsel_vector_ctrl`

## Requirements
- R1: While reset is low, and after it is released, `addr_o` is 63, `sel_o` is all zero, `clk_en_o` is 1, and `restart_o` and `clear_o` are 0.
- R2: A falling edge of `load_n` with `auto_inc_i`=0 loads `bus_i` into `addr_o`. The new value is visible one `clk` cycle after the edge is sampled. A rising edge of `load_n` never changes `addr_o`.
- R3: Address k, for 0 ≤ k ≤ 18, drives `sel_o` bit k alone. Every other address drives `sel_o` to all zero. At most one bit of `sel_o` is ever high.
- R4: Loading address 22 or 54 sets `restart_o`=1 and `clk_en_o`=0.
- R5: Loading address 23 or 55 sets `clear_o`=1 and `clk_en_o`=0.
- R6: Loading the same command address again, or pulsing `load_n` in auto mode while the address is a command, leaves the state and the outputs unchanged.
- R7: When an ordinary address is loaded from a command state, `restart_o` and `clear_o` drop on that falling edge. `clk_en_o` stays 0 until the rising edge of that same strobe, and returns to 1 one cycle after that rising edge is sampled.
- R8: In auto mode (`auto_inc_i`=1), a falling edge increments an ordinary address by one, and address 63 wraps to 0.
- R9: In auto mode, a command address does not increment. It keeps pointing at itself until a new address is loaded with `auto_inc_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `load_n` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load strobe, synchronous to `clk` |
| auto_inc_i | input | 1 | 0: the bus carries an address; 1: auto-addressing data load |
| bus_i | input | 6 | Address value captured on a strobe fall |
| addr_o | output | 6 | Current address register |
| sel_o | output | NUM_DATA_REGS+1 | One-hot register select (bit 0 = status) |
| clk_en_o | output | 1 | Enable for the device's internal clock |
| restart_o | output | 1 | High while in the Restart state |
| clear_o | output | 1 | High while in the Clear state |

## Verification
The bench goes after the boundary addresses 0, 18 and 19, where an off-by-one decoder would select a register that does not exist or drop the last one. It tests the wrap from 63 to 0 in auto mode, where a wrong width or a saturating counter would stick at 63. It pulses the strobe in auto mode while the address is a command; a design that increments there would leave the command state by itself. It also samples `clk_en_o` between the falling and rising edges of a releasing load, where a design that resumes too early would let the counters run one strobe too soon. A seeded random mix of address loads, auto loads and command addresses is then checked against a reference model in the bench.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_RESTART = 2'd1,
        ST_CLEAR   = 2'd2,
        ST_RESUME  = 2'd3
    } vec_state_t;

    function automatic logic is_restart_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(22)) || (a == ADDR_W'(54));
    endfunction

    function automatic logic is_clear_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(23)) || (a == ADDR_W'(55));
    endfunction

    function automatic logic is_cmd_addr(input logic [ADDR_W-1:0] a);
        return is_restart_addr(a) || is_clear_addr(a);
    endfunction

endpackage

// File: rtl/regsel_addr_reg.sv
module regsel_addr_reg
    import regsel_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              auto_inc_i,
    input  logic [ADDR_W-1:0] bus_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] addr_nxt_o,
    output logic              fall_o,
    output logic              rise_o
);

    logic              load_q;
    logic [ADDR_W-1:0] addr_q;

    assign fall_o = load_q & ~load_n;
    assign rise_o = ~load_q & load_n;
    assign addr_o = addr_q;

    always_comb begin
        addr_nxt_o = addr_q;
        if (fall_o) begin
            if (!auto_inc_i) begin
                addr_nxt_o = bus_i;
            end else if (!is_cmd_addr(addr_q)) begin
                addr_nxt_o = addr_q + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= 1'b1;
            addr_q <= RESET_ADDR;
        end else begin
            load_q <= load_n;
            addr_q <= addr_nxt_o;
        end
    end

    a_r2_hold_without_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_o |=> $stable(addr_q));

    a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o && auto_inc_i && addr_q == '1) |=> (addr_q == '0));

    a_r9_cmd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_o && auto_inc_i && is_cmd_addr(addr_q)) |=> $stable(addr_q));

endmodule

// File: rtl/regsel_decode.sv
module regsel_decode
    import regsel_pkg::*;
#(
    parameter int NUM_DATA_REGS = 18
) (
    input  logic [ADDR_W-1:0]      addr_i,
    output logic [NUM_DATA_REGS:0] sel_o
);

    localparam int NSEL = NUM_DATA_REGS + 1;

    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel_o[i] = (addr_i == ADDR_W'(i));
    end

endmodule

// File: rtl/regsel_vec_fsm.sv
module regsel_vec_fsm
    import regsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [ADDR_W-1:0] addr_nxt_i,
    output logic              clk_en_o,
    output logic              restart_o,
    output logic              clear_o
);

    vec_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (fall_i) begin
            if (is_restart_addr(addr_nxt_i)) begin
                state_d = ST_RESTART;
            end else if (is_clear_addr(addr_nxt_i)) begin
                state_d = ST_CLEAR;
            end else if (state_q != ST_RUN) begin
                state_d = ST_RESUME;
            end
        end else if (rise_i && state_q == ST_RESUME) begin
            state_d = ST_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        clk_en_o  = 1'b0;
        restart_o = 1'b0;
        clear_o   = 1'b0;
        unique case (state_q)
            ST_RUN:     clk_en_o  = 1'b1;
            ST_RESTART: restart_o = 1'b1;
            ST_CLEAR:   clear_o   = 1'b1;
            ST_RESUME:  clk_en_o  = 1'b0;
            default:    clk_en_o  = 1'b0;
        endcase
    end

    a_r5_clear_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && is_clear_addr(addr_nxt_i)) |=> (clear_o && !clk_en_o));

    a_r6_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o && fall_i && is_restart_addr(addr_nxt_i)) |=> restart_o);

    a_r7_wait_for_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME && !rise_i && !fall_i) |=> !clk_en_o);

    a_r7_resume_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESUME && rise_i) |=> clk_en_o);

endmodule

// File: rtl/regsel_vector_ctrl.sv
module regsel_vector_ctrl
    import regsel_pkg::*;
#(
    parameter int                NUM_DATA_REGS = 18,
    parameter logic [ADDR_W-1:0] RESET_ADDR    = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_n,
    input  logic                     auto_inc_i,
    input  logic [ADDR_W-1:0]        bus_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [NUM_DATA_REGS:0]   sel_o,
    output logic                     clk_en_o,
    output logic                     restart_o,
    output logic                     clear_o
);

    logic [ADDR_W-1:0] addr_nxt;
    logic              fall;
    logic              rise;

    regsel_addr_reg #(.RESET_ADDR(RESET_ADDR)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .auto_inc_i (auto_inc_i),
        .bus_i      (bus_i),
        .addr_o     (addr_o),
        .addr_nxt_o (addr_nxt),
        .fall_o     (fall),
        .rise_o     (rise)
    );

    regsel_decode #(.NUM_DATA_REGS(NUM_DATA_REGS)) u_dec (
        .addr_i (addr_o),
        .sel_o  (sel_o)
    );

    regsel_vec_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .rise_i     (rise),
        .addr_nxt_i (addr_nxt),
        .clk_en_o   (clk_en_o),
        .restart_o  (restart_o),
        .clear_o    (clear_o)
    );

    a_r3_at_most_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    a_r4_cmd_gates_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_o || clear_o) |-> !clk_en_o);

    a_r4_cmd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(restart_o && clear_o));

endmodule

// File: tb/regsel_vector_ctrl_tb.sv
module regsel_vector_ctrl_tb_top;

    localparam int NR = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          auto_inc_i = 1'b0;
    logic [5:0]    bus_i = '0;
    logic [5:0]    addr_o;
    logic [NR:0]   sel_o;
    logic          clk_en_o, restart_o, clear_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: 0 run, 1 restart, 2 clear, 3 resume
    int m_addr;
    int m_st;

    always #2.5 clk = ~clk;

    regsel_vector_ctrl #(.NUM_DATA_REGS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .auto_inc_i(auto_inc_i),
        .bus_i(bus_i), .addr_o(addr_o), .sel_o(sel_o), .clk_en_o(clk_en_o),
        .restart_o(restart_o), .clear_o(clear_o)
    );

    function automatic bit f_restart(int a); return a == 22 || a == 54; endfunction
    function automatic bit f_clear(int a);   return a == 23 || a == 55; endfunction
    function automatic bit f_cmd(int a);     return f_restart(a) || f_clear(a); endfunction

    function automatic logic [NR:0] f_sel(int a);
        logic [NR:0] s = '0;
        if (a >= 0 && a <= NR) s[a] = 1'b1;
        return s;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        chk("R2", {ctx, " addr"}, 32'(addr_o), 32'(m_addr));
        chk("R3", {ctx, " sel"}, 32'(sel_o), 32'(f_sel(m_addr)));
        chk("R7", {ctx, " clk_en"}, 32'(clk_en_o), 32'(m_st == 0));
        chk("R4", {ctx, " restart"}, 32'(restart_o), 32'(m_st == 1));
        chk("R5", {ctx, " clear"}, 32'(clear_o), 32'(m_st == 2));
    endtask

    task automatic model_fall(bit auto_m, int b);
        if (!auto_m) m_addr = b;
        else if (!f_cmd(m_addr)) m_addr = (m_addr + 1) % 64;
        if (f_restart(m_addr))    m_st = 1;
        else if (f_clear(m_addr)) m_st = 2;
        else if (m_st != 0)       m_st = 3;
    endtask

    // one strobe: checks after the fall and after the rise
    task automatic strobe(bit auto_m, int b, string ctx);
        @(negedge clk);
        auto_inc_i = auto_m;
        bus_i = 6'(b);
        load_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_fall(auto_m, b);
        check_all({ctx, " fall"});
        load_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (m_st == 3) m_st = 0;
        check_all({ctx, " rise"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_val;
        m_addr = 63;
        m_st = 0;
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_all("R1 after reset");

        strobe(0, 5,  "R3 addr5");
        strobe(0, 0,  "R3 status");
        strobe(0, 18, "R3 last data reg");
        strobe(0, 19, "R3 first unused");
        strobe(0, 40, "R3 high addr");
        strobe(1, 0,  "R8 step from 40");
        strobe(0, 63, "R8 load 63");
        strobe(1, 0,  "R8 wrap");
        strobe(1, 0,  "R8 step from 0");

        strobe(0, 22, "R4 restart 22");
        strobe(0, 22, "R6 reload 22");
        strobe(1, 0,  "R9 auto on 22");
        strobe(0, 54, "R4 restart 54");
        // R7: check clk_en between fall and rise of a releasing load
        @(negedge clk);
        auto_inc_i = 0; bus_i = 6'd7; load_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_fall(0, 7);
        check_all("R7 released, strobe low");
        repeat (3) @(negedge clk);
        check_all("R7 still waiting for rise");
        load_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_st = 0;
        check_all("R7 resumed after rise");

        strobe(0, 23, "R5 clear 23");
        strobe(1, 0,  "R9 auto on 23");
        strobe(0, 55, "R5 clear 55");
        strobe(0, 55, "R6 reload 55");
        strobe(0, 1,  "R7 release to 1");

        seed_val = $urandom(32'd20240611);
        for (int i = 0; i < 400; i++) begin
            int r;
            int b;
            bit am;
            r = $urandom_range(0, 9);
            am = (r < 3);
            case ($urandom_range(0, 3))
                0:       b = 22 + 32 * $urandom_range(0, 1);
                1:       b = 23 + 32 * $urandom_range(0, 1);
                2:       b = $urandom_range(0, 20);
                default: b = $urandom_range(0, 63);
            endcase
            strobe(am, b, "RND");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule